// File: doc/BRIEF.md
# Dual-Mode Dual-Clock FIFO

A first-in, first-out buffer whose write port and read port run on their own clocks. Words are written on the write clock while an active-low write enable is held low. They leave on the read clock. Each side keeps a binary pointer and a Gray copy of it. The Gray copy crosses to the other side through a two-flop synchroniser. Each side derives its own flags from its local pointer and the synchronised remote pointer.

The operating mode is latched from a select input while master reset is held. In standard mode every word, the first included, is fetched by pulling read enable low on a read clock edge. The read status flag then means "words are stored" and the write status flag means "room to write". In fall-through mode the oldest word moves into the output register on its own. The read status flag then means "the output holds a valid word", and read enable only discards that word so the next one can take its place. Both status flags change polarity between the two modes.

Top module: `dmf_fifo`

## Requirements
- R1: The mode is captured from `fwft_sel` on every write and read clock edge while `rst_n` is low. 0 selects standard mode and 1 selects fall-through mode. The choice holds until the next reset, whatever `fwft_sel` does afterwards. After reset, `rd_stat` is 0 and `wr_stat` is 1 in standard mode; `rd_stat` is 1 and `wr_stat` is 0 in fall-through mode.
- R2: In standard mode, `rd_stat` is 1 when at least one word is stored and 0 when none is. After a write into an empty FIFO it rises on the second read clock edge that follows the write edge.
- R3: In standard mode, `rd_data` changes only on a read clock edge where `rd_en_n` is low and `rd_stat` is 1. It then shows the oldest stored word. No word reaches `rd_data` without such a read.
- R4: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_stat` low after the third read clock edge that follows the write edge, with `rd_en_n` held high.
- R5: In fall-through mode, a valid word stays on `rd_data` until a read clock edge with `rd_en_n` low. That edge replaces it with the next word, in write order, or sets `rd_stat` to 1 if no word is stored.
- R6: Each write clock edge with `wr_en_n` low stores `wr_data` in order unless the FIFO is full. A write offered while full is discarded in both modes and never appears on `rd_data`.
- R7: When the storage array holds its full depth, `wr_stat` is 0 in standard mode and 1 in fall-through mode.
- R8: After a read frees a location in a full FIFO, `wr_stat` leaves its full value on the second write clock edge after the read edge, not sooner.
- R9: A read request made while no word is available (standard: `rd_stat` 0; fall-through: `rd_stat` 1) moves neither the read pointer nor `rd_data`. The next word written is the next word read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Master reset, active low; mode is sampled while low |
| fwft_sel | input | 1 | Mode select: 0 standard, 1 fall-through |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DW | Word to store |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DW | Registered output word |
| rd_stat | output | 1 | Standard: 1 = words stored; fall-through: 0 = output valid |
| wr_stat | output | 1 | Standard: 0 = full; fall-through: 1 = full |

## Verification
The bench builds the block with a depth of 8 and a 36-bit word and drives both clock ports from one clock. The small depth lets directed sequences reach the full boundary in a few cycles and lets the random phase wrap the pointers many times in each mode. The shared clock makes the two-edge and three-edge synchroniser latencies land on exact, predictable cycles, so the flag timing is checked edge by edge.

// File: rtl/dmf_pkg.sv
package dmf_pkg;
  typedef enum logic {MODE_STD = 1'b0, MODE_FWFT = 1'b1} fifo_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  // pointers are AW+1 bits wide; full when the two top Gray bits differ and the rest match
  function automatic logic ring_full(input logic [31:0] wg, input logic [31:0] rg, input int aw);
    return wg == (rg ^ (32'd3 << (aw - 1)));
  endfunction

  function automatic logic ring_empty(input logic [31:0] rg, input logic [31:0] wg);
    return rg == wg;
  endfunction
endpackage

// File: rtl/dmf_sync.sv
module dmf_sync #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      hold_q <= '0;
    end else begin
      meta_q <= d;
      hold_q <= meta_q;
    end
  end

  assign q = hold_q;
endmodule

// File: rtl/dmf_wr_side.sv
module dmf_wr_side
  import dmf_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          wr_clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wr_en_n,
  input  logic [AW:0]   rq2_gray,
  output logic          wr_fire,
  output logic [AW-1:0] waddr,
  output logic [AW:0]   wgray,
  output logic          wr_stat
);
  localparam int PW = AW + 1;

  fifo_mode_e   mode_q;
  logic [PW-1:0] wbin_q, wgray_q, wbin_n;
  logic          full_w;

  always_ff @(posedge wr_clk) begin
    if (!rst_n) mode_q <= fifo_mode_e'(fwft_sel);
  end

  assign full_w  = ring_full(32'(wgray_q), 32'(rq2_gray), AW);
  assign wr_fire = !wr_en_n && !full_w;
  assign wbin_n  = wbin_q + PW'(1);

  always_ff @(posedge wr_clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin_q  <= '0;
      wgray_q <= '0;
    end else if (wr_fire) begin
      wbin_q  <= wbin_n;
      wgray_q <= PW'(bin2gray(32'(wbin_n)));
    end
  end

  assign waddr   = wbin_q[AW-1:0];
  assign wgray   = wgray_q;
  assign wr_stat = (mode_q == MODE_FWFT) ? full_w : !full_w;

  // R6: a full array freezes the write pointer
  a_r6_no_overflow: assert property (@(posedge wr_clk) disable iff (!rst_n)
    full_w |=> $stable(wbin_q));
  // R6: an accepted write advances the pointer by exactly one
  a_r6_write_step: assert property (@(posedge wr_clk) disable iff (!rst_n)
    (!wr_en_n && !full_w) |=> (wbin_q == $past(wbin_q) + PW'(1)));
  // R8: the crossing pointer changes at most one bit per edge
  a_r8_gray_onestep: assert property (@(posedge wr_clk) disable iff (!rst_n)
    $countones(wgray_q ^ $past(wgray_q)) <= 1);
  // R1: the mode stays fixed outside reset
  a_r1_wmode_hold: assert property (@(posedge wr_clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dmf_rd_side.sv
module dmf_rd_side
  import dmf_pkg::*;
#(
  parameter int DW = 36,
  parameter int AW = 4
) (
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          rd_en_n,
  input  logic [AW:0]   wq2_gray,
  input  logic [DW-1:0] mem_q,
  output logic [AW-1:0] raddr,
  output logic [AW:0]   rgray,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat
);
  localparam int PW = AW + 1;

  fifo_mode_e    mode_q;
  logic [PW-1:0] rbin_q, rgray_q, rbin_n;
  logic [DW-1:0] data_q;
  logic          ov_q, mem_empty, std_take, fw_take, pop, is_fwft;

  always_ff @(posedge rd_clk) begin
    if (!rst_n) mode_q <= fifo_mode_e'(fwft_sel);
  end

  assign is_fwft   = (mode_q == MODE_FWFT);
  assign mem_empty = ring_empty(32'(rgray_q), 32'(wq2_gray));
  assign std_take  = !is_fwft && !rd_en_n && !mem_empty;
  assign fw_take   = is_fwft && !mem_empty && (!ov_q || !rd_en_n);
  assign pop       = std_take || fw_take;
  assign rbin_n    = rbin_q + PW'(1);

  always_ff @(posedge rd_clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin_q  <= '0;
      rgray_q <= '0;
      data_q  <= '0;
      ov_q    <= 1'b0;
    end else begin
      if (pop) begin
        rbin_q  <= rbin_n;
        rgray_q <= PW'(bin2gray(32'(rbin_n)));
        data_q  <= mem_q;
      end
      if (fw_take)                          ov_q <= 1'b1;
      else if (is_fwft && !rd_en_n)         ov_q <= 1'b0;
    end
  end

  assign raddr   = rbin_q[AW-1:0];
  assign rgray   = rgray_q;
  assign rd_data = data_q;
  assign rd_stat = is_fwft ? !ov_q : !mem_empty;

  // R9: nothing stored means the read pointer does not move
  a_r9_no_underflow: assert property (@(posedge rd_clk) disable iff (!rst_n)
    mem_empty |=> $stable(rbin_q));
  // R3: standard mode output only changes on a requested read
  a_r3_std_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (!is_fwft && rd_en_n) |=> $stable(data_q));
  // R5: a valid fall-through word is held until read
  a_r5_fwft_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    (is_fwft && ov_q && rd_en_n) |=> ($stable(data_q) && ov_q));
  // R8: the crossing pointer changes at most one bit per edge
  a_r8_rgray_onestep: assert property (@(posedge rd_clk) disable iff (!rst_n)
    $countones(rgray_q ^ $past(rgray_q)) <= 1);
  // R1: the mode stays fixed outside reset
  a_r1_rmode_hold: assert property (@(posedge rd_clk) disable iff (!rst_n)
    1'b1 |=> $stable(mode_q));
endmodule

// File: rtl/dmf_fifo.sv
module dmf_fifo #(
  parameter int DW    = 36,
  parameter int DEPTH = 16
) (
  input  logic          wr_clk,
  input  logic          rd_clk,
  input  logic          rst_n,
  input  logic          fwft_sel,
  input  logic          wr_en_n,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en_n,
  output logic [DW-1:0] rd_data,
  output logic          rd_stat,
  output logic          wr_stat
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem_a [DEPTH];
  logic [DW-1:0] mem_q;
  logic [AW-1:0] waddr, raddr;
  logic [AW:0]   wgray, rgray, wq2_gray, rq2_gray;
  logic          wr_fire;

  initial begin
    assert (DEPTH >= 4 && DEPTH == (1 << AW)) else $error("DEPTH must be a power of two >= 4");
  end

  dmf_wr_side #(.AW(AW)) u_wr (
    .wr_clk(wr_clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .wr_en_n(wr_en_n),
    .rq2_gray(rq2_gray), .wr_fire(wr_fire), .waddr(waddr), .wgray(wgray),
    .wr_stat(wr_stat));

  dmf_rd_side #(.DW(DW), .AW(AW)) u_rd (
    .rd_clk(rd_clk), .rst_n(rst_n), .fwft_sel(fwft_sel), .rd_en_n(rd_en_n),
    .wq2_gray(wq2_gray), .mem_q(mem_q), .raddr(raddr), .rgray(rgray),
    .rd_data(rd_data), .rd_stat(rd_stat));

  dmf_sync #(.W(AW + 1)) u_w2r (.clk(rd_clk), .rst_n(rst_n), .d(wgray), .q(wq2_gray));
  dmf_sync #(.W(AW + 1)) u_r2w (.clk(wr_clk), .rst_n(rst_n), .d(rgray), .q(rq2_gray));

  always_ff @(posedge wr_clk) begin
    if (wr_fire) mem_a[waddr] <= wr_data;
  end

  assign mem_q = mem_a[raddr];
endmodule

// File: tb/dmf_fifo_test.sv
module dmf_fifo_test;
  localparam int DW = 36;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fwft_sel = 1'b0;
  logic wr_en_n = 1'b1;
  logic rd_en_n = 1'b1;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic rd_stat, wr_stat;
  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [DW-1:0] model_q[$];

  always #2 clk = ~clk;

  dmf_fifo #(.DW(DW), .DEPTH(DEPTH)) uut (
    .wr_clk(clk), .rd_clk(clk), .rst_n(rst_n), .fwft_sel(fwft_sel),
    .wr_en_n(wr_en_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rd_data(rd_data), .rd_stat(rd_stat), .wr_stat(wr_stat));

  function automatic logic [DW-1:0] pat(input int i);
    return {4'ha, 16'(i), ~16'(i)};
  endfunction
  function automatic logic exp_wstat(input logic fw, input logic full);
    return fw ? full : !full;
  endfunction
  function automatic logic exp_rstat(input logic fw, input logic avail);
    return fw ? !avail : avail;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic fw);
    rst_n = 1'b0; fwft_sel = fw; wr_en_n = 1'b1; rd_en_n = 1'b1;
    repeat (3) tick();
    rst_n = 1'b1; fwft_sel = !fw;
    tick();
    model_q.delete();
  endtask

  task automatic put(input logic [DW-1:0] d);
    wr_en_n = 1'b0; wr_data = d; tick(); wr_en_n = 1'b1;
  endtask

  task automatic random_phase(input logic fw, input int n);
    for (int k = 0; k < n; k++) begin
      logic we, re, avail, took;
      logic [DW-1:0] e;
      we = ($urandom % 3) != 0;
      re = ($urandom % 2) != 0;
      took = 1'b0;
      e = '0;
      avail = (rd_stat == exp_rstat(fw, 1'b1));
      if (fw && avail) chk("R5 random front", 64'(rd_data), 64'(model_q[0]));
      if (re && avail) begin e = model_q.pop_front(); took = 1'b1; end
      if (we && wr_stat == exp_wstat(fw, 1'b0)) model_q.push_back(pat(1000 + k));
      wr_en_n = !we; wr_data = pat(1000 + k); rd_en_n = !re;
      tick();
      if (!fw && took) chk("R3 R6 random order", 64'(rd_data), 64'(e));
    end
    wr_en_n = 1'b1; rd_en_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    // ---------------- standard mode ----------------
    do_reset(1'b0);
    chk("R1 std rd_stat reset", 64'(rd_stat), 64'(exp_rstat(1'b0, 1'b0)));
    chk("R1 std wr_stat reset", 64'(wr_stat), 64'(exp_wstat(1'b0, 1'b0)));
    put(pat(1));
    chk("R2 empty after write edge", 64'(rd_stat), 64'd0);
    tick(); chk("R2 empty after edge 1", 64'(rd_stat), 64'd0);
    tick(); chk("R2 data seen at edge 2", 64'(rd_stat), 64'd1);
    tick(); tick();
    chk("R3 no word without read", 64'(rd_data), 64'd0);
    rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
    chk("R3 first word on read", 64'(rd_data), 64'(pat(1)));
    chk("R2 empty again", 64'(rd_stat), 64'd0);
    rd_en_n = 1'b0; tick(); tick(); rd_en_n = 1'b1;
    chk("R9 std empty read data", 64'(rd_data), 64'(pat(1)));
    put(pat(2)); tick(); tick();
    chk("R9 std next avail", 64'(rd_stat), 64'd1);
    rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
    chk("R9 std pointer kept", 64'(rd_data), 64'(pat(2)));
    for (int i = 0; i < DEPTH; i++) put(pat(10 + i));
    chk("R7 std full", 64'(wr_stat), 64'(exp_wstat(1'b0, 1'b1)));
    put(pat(99));
    chk("R6 std still full", 64'(wr_stat), 64'd0);
    tick(); tick();
    rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
    chk("R6 std oldest", 64'(rd_data), 64'(pat(10)));
    chk("R8 std full held r0", 64'(wr_stat), 64'd0);
    tick(); chk("R8 std full held r1", 64'(wr_stat), 64'd0);
    tick(); chk("R8 std released r2", 64'(wr_stat), 64'd1);
    for (int i = 1; i < DEPTH; i++) begin
      rd_en_n = 1'b0; tick();
      chk("R6 std fill order", 64'(rd_data), 64'(pat(10 + i)));
    end
    rd_en_n = 1'b1;
    chk("R6 std overflow dropped", 64'(rd_stat), 64'd0);
    random_phase(1'b0, 400);

    // ---------------- fall-through mode ----------------
    do_reset(1'b1);
    chk("R1 fw rd_stat reset", 64'(rd_stat), 64'(exp_rstat(1'b1, 1'b0)));
    chk("R1 fw wr_stat reset", 64'(wr_stat), 64'(exp_wstat(1'b1, 1'b0)));
    put(pat(3));
    chk("R4 not valid e0", 64'(rd_stat), 64'd1);
    tick(); chk("R4 not valid e1", 64'(rd_stat), 64'd1);
    tick(); chk("R4 not valid e2", 64'(rd_stat), 64'd1);
    tick(); chk("R4 valid e3", 64'(rd_stat), 64'd0);
    chk("R4 word e3", 64'(rd_data), 64'(pat(3)));
    put(pat(4)); put(pat(5)); tick(); tick(); tick();
    chk("R5 held without read", 64'(rd_data), 64'(pat(3)));
    rd_en_n = 1'b0; tick();
    chk("R5 second word", 64'(rd_data), 64'(pat(4)));
    tick();
    chk("R5 third word", 64'(rd_data), 64'(pat(5)));
    tick(); rd_en_n = 1'b1;
    chk("R5 drained", 64'(rd_stat), 64'd1);
    chk("R9 fw data kept", 64'(rd_data), 64'(pat(5)));
    rd_en_n = 1'b0; tick(); tick(); rd_en_n = 1'b1;
    chk("R9 fw idle read data", 64'(rd_data), 64'(pat(5)));
    put(pat(6)); tick(); tick();
    chk("R9 fw not yet", 64'(rd_stat), 64'd1);
    tick();
    chk("R9 fw pointer kept", 64'(rd_data), 64'(pat(6)));
    for (int i = 0; i < DEPTH; i++) put(pat(20 + i));
    chk("R7 fw full", 64'(wr_stat), 64'(exp_wstat(1'b1, 1'b1)));
    put(pat(98));
    chk("R6 fw still full", 64'(wr_stat), 64'd1);
    rd_en_n = 1'b0; tick(); rd_en_n = 1'b1;
    chk("R5 fw next after full", 64'(rd_data), 64'(pat(20)));
    chk("R8 fw full held r0", 64'(wr_stat), 64'd1);
    tick(); chk("R8 fw full held r1", 64'(wr_stat), 64'd1);
    tick(); chk("R8 fw released r2", 64'(wr_stat), 64'd0);
    for (int i = 1; i < DEPTH; i++) begin
      rd_en_n = 1'b0; tick();
      chk("R6 fw fill order", 64'(rd_data), 64'(pat(20 + i)));
    end
    tick(); rd_en_n = 1'b1;
    chk("R6 fw overflow dropped", 64'(rd_stat), 64'd1);
    random_phase(1'b1, 400);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule